// File: doc/BRIEF.md
# Ping-Pong Neuron State Store

This block keeps neuron states in two equal banks that are used alternately. At any moment the host port owns one bank and the compute port owns the other. The host can fill or drain a whole image while the compute engine reads inputs from, and writes results to, the other bank. The host asks for a role exchange, and the exchange waits until the compute port is not accessing memory.

The two ports see the same storage at different widths. The host port moves a full word of four packed 3-bit states per access. The compute port sees a four-times-deeper memory of single 3-bit states. Its two low address bits pick the state inside a word, and a compute write changes only that state. With `HOST_AW` set to 14, each bank holds 16K words of 12 bits, which is 64K states. The default of 8 keeps the arrays small.

The ownership controller is a four-state machine. In `OWN0` the host owns bank 0 and the compute port owns bank 1. In `OWN1` the roles are reversed. `OWN0_WAIT` and `OWN1_WAIT` mean the same ownership as `OWN0` and `OWN1`, with a swap request waiting. The transitions are:

| Transition | Condition |
|---|---|
| `OWN0` to `OWN1` | swap request while `c_en` is low |
| `OWN0` to `OWN0_WAIT` | swap request while `c_en` is high |
| `OWN0_WAIT` to `OWN1` | the first cycle with `c_en` low |
| `OWN0_WAIT` stays in `OWN0_WAIT` | `c_en` is high |
| `OWN1` and `OWN1_WAIT` | mirror the four rows above |

Top module: `pp_state_store`

## Requirements
- R1: After reset the host owns bank 0 (`host_bank`=0) and no swap is pending (`swap_pend`=0).
- R2: A host write stores a whole 12-bit word in the host-owned bank. A host read returns that word on `h_rdata` in the cycle after the request.
- R3: On the compute port, `c_addr[HOST_AW+1:2]` selects the word and `c_addr[1:0]` selects state k, which is word bits [3k+2:3k]. A compute read returns the state on `c_rdata` in the cycle after the request.
- R4: A compute write changes only the addressed 3-bit state. The other three states of that word keep their values.
- R5: The two ports always reach different banks. A write on one port cannot be seen by the other port until after a swap.
- R6: A swap request in a cycle with `c_en` low flips `host_bank` from the next cycle on.
- R7: A swap request in a cycle with `c_en` high raises `swap_pend` and leaves `host_bank` unchanged. The flip happens after the first later cycle with `c_en` low, and `swap_pend` clears at the same time.
- R8: Swap requests that arrive while a swap is already pending are absorbed, so a pending swap causes exactly one flip. With no request and nothing pending, `host_bank` stays the same.
- R9: A read issued in the same cycle that a swap takes effect returns data from the bank its port owned when the read was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| swap_req | input | 1 | one-cycle request to exchange bank roles |
| host_bank | output | 1 | index of the bank the host currently owns |
| swap_pend | output | 1 | a swap is waiting for the compute port to go idle |
| h_en | input | 1 | host access strobe |
| h_we | input | 1 | host write (1) or read (0) |
| h_addr | input | HOST_AW | host word address |
| h_wdata | input | 12 | host write word |
| h_rdata | output | 12 | host read word, one cycle after the request |
| c_en | input | 1 | compute access strobe; low means the compute port is idle |
| c_we | input | 1 | compute write (1) or read (0) |
| c_addr | input | HOST_AW+2 | compute state address |
| c_wdata | input | 3 | compute write state |
| c_rdata | output | 3 | compute read state, one cycle after the request |

## Verification
The bench writes the four states of a word one at a time through the compute port. It then overwrites one of them and reads the whole word back through the host after a swap. A wrong slice order or a write that is not masked would corrupt the neighbouring states. It issues host writes into the host bank while the compute port reads the same word index in its own bank. A design that steers both ports to one bank would leak that data across. It sends swap requests while the compute port is busy, sends a second request while the first is pending, and places a host read in the very cycle a swap takes effect. These cases catch a premature flip, a double flip, and read data taken from the new bank instead of the old one.

// File: rtl/pp_store_pkg.sv
package pp_store_pkg;
    // Bank ownership and swap handshake states
    typedef enum logic [1:0] {
        OWN0      = 2'd0,
        OWN1      = 2'd1,
        OWN0_WAIT = 2'd2,
        OWN1_WAIT = 2'd3
    } own_state_t;
endpackage

// File: rtl/pp_bank.sv
module pp_bank #(
    parameter int WORD_W = 12,
    parameter int SLICES = 4,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [SLICES-1:0] wmask,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int SW    = WORD_W / SLICES;
    localparam int DEPTH = 1 << AW;

    // One narrow array per state lane gives independent write enables
    for (genvar s = 0; s < SLICES; s++) begin : g_lane
        logic [SW-1:0] mem [DEPTH];
        logic [SW-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (en && we && wmask[s]) begin
                mem[addr] <= wdata[s*SW +: SW];
            end
        end

        always_ff @(posedge clk) begin
            if (en && !we) begin
                rd_q <= mem[addr];
            end
        end

        assign rdata[s*SW +: SW] = rd_q;
    end
endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl
    import pp_store_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic c_busy,
    output logic host_bank,
    output logic swap_pend
);
    own_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWN0;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN0: begin
                if (swap_req) state_d = c_busy ? OWN0_WAIT : OWN1;
            end
            OWN1: begin
                if (swap_req) state_d = c_busy ? OWN1_WAIT : OWN0;
            end
            OWN0_WAIT: begin
                if (!c_busy) state_d = OWN1;
            end
            OWN1_WAIT: begin
                if (!c_busy) state_d = OWN0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        host_bank = 1'b0;
        swap_pend = 1'b0;
        unique case (state_q)
            OWN0:      begin host_bank = 1'b0; swap_pend = 1'b0; end
            OWN1:      begin host_bank = 1'b1; swap_pend = 1'b0; end
            OWN0_WAIT: begin host_bank = 1'b0; swap_pend = 1'b1; end
            OWN1_WAIT: begin host_bank = 1'b1; swap_pend = 1'b1; end
        endcase
    end
endmodule

// File: rtl/pp_slice_adapt.sv
module pp_slice_adapt #(
    parameter int WORD_W = 12,
    parameter int SLICES = 4,
    parameter int AW     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        c_en,
    input  logic                        c_we,
    input  logic [AW+$clog2(SLICES)-1:0] c_addr,
    input  logic [WORD_W/SLICES-1:0]    c_wdata,
    input  logic [WORD_W-1:0]           word_rdata,
    output logic [AW-1:0]               w_addr,
    output logic [SLICES-1:0]           w_mask,
    output logic [WORD_W-1:0]           w_wdata,
    output logic [WORD_W/SLICES-1:0]    c_rdata
);
    localparam int SW  = WORD_W / SLICES;
    localparam int SLW = $clog2(SLICES);

    logic [SLW-1:0] sel_q;

    assign w_addr  = c_addr[AW+SLW-1:SLW];
    assign w_wdata = {SLICES{c_wdata}};

    for (genvar s = 0; s < SLICES; s++) begin : g_mask
        assign w_mask[s] = (c_addr[SLW-1:0] == SLW'(s));
    end

    // Remember which lane the pending read wants
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              sel_q <= '0;
        else if (c_en && !c_we)  sel_q <= c_addr[SLW-1:0];
    end

    assign c_rdata = word_rdata[sel_q*SW +: SW];
endmodule

// File: rtl/pp_state_store.sv
module pp_state_store #(
    parameter int WORD_W  = 12,
    parameter int SLICES  = 4,
    parameter int HOST_AW = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              swap_req,
    output logic                              host_bank,
    output logic                              swap_pend,
    input  logic                              h_en,
    input  logic                              h_we,
    input  logic [HOST_AW-1:0]                h_addr,
    input  logic [WORD_W-1:0]                 h_wdata,
    output logic [WORD_W-1:0]                 h_rdata,
    input  logic                              c_en,
    input  logic                              c_we,
    input  logic [HOST_AW+$clog2(SLICES)-1:0] c_addr,
    input  logic [WORD_W/SLICES-1:0]          c_wdata,
    output logic [WORD_W/SLICES-1:0]          c_rdata
);
    localparam int SW    = WORD_W / SLICES;
    localparam int NBANK = 2;

    logic [HOST_AW-1:0] cw_addr;
    logic [SLICES-1:0]  cw_mask;
    logic [WORD_W-1:0]  cw_wdata;
    logic [WORD_W-1:0]  cw_rdata;

    logic               b_en    [NBANK];
    logic               b_we    [NBANK];
    logic [SLICES-1:0]  b_mask  [NBANK];
    logic [HOST_AW-1:0] b_addr  [NBANK];
    logic [WORD_W-1:0]  b_wdata [NBANK];
    logic [WORD_W-1:0]  b_rdata [NBANK];

    logic h_sel_q;
    logic c_sel_q;

    pp_swap_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_req  (swap_req),
        .c_busy    (c_en),
        .host_bank (host_bank),
        .swap_pend (swap_pend)
    );

    pp_slice_adapt #(
        .WORD_W (WORD_W),
        .SLICES (SLICES),
        .AW     (HOST_AW)
    ) u_adapt (
        .clk        (clk),
        .rst_n      (rst_n),
        .c_en       (c_en),
        .c_we       (c_we),
        .c_addr     (c_addr),
        .c_wdata    (c_wdata),
        .word_rdata (cw_rdata),
        .w_addr     (cw_addr),
        .w_mask     (cw_mask),
        .w_wdata    (cw_wdata),
        .c_rdata    (c_rdata)
    );

    // Steer each bank to whichever port owns it
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic own_host;
        assign own_host   = (host_bank == 1'(b));
        assign b_en[b]    = own_host ? h_en    : c_en;
        assign b_we[b]    = own_host ? h_we    : c_we;
        assign b_mask[b]  = own_host ? '1      : cw_mask;
        assign b_addr[b]  = own_host ? h_addr  : cw_addr;
        assign b_wdata[b] = own_host ? h_wdata : cw_wdata;

        pp_bank #(
            .WORD_W (WORD_W),
            .SLICES (SLICES),
            .AW     (HOST_AW)
        ) u_bank (
            .clk   (clk),
            .en    (b_en[b]),
            .we    (b_we[b]),
            .wmask (b_mask[b]),
            .addr  (b_addr[b]),
            .wdata (b_wdata[b]),
            .rdata (b_rdata[b])
        );
    end

    // Bank each read came from, captured at issue time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_sel_q <= 1'b0;
            c_sel_q <= 1'b1;
        end else begin
            if (h_en && !h_we) h_sel_q <= host_bank;
            if (c_en && !c_we) c_sel_q <= ~host_bank;
        end
    end

    assign h_rdata  = b_rdata[h_sel_q];
    assign cw_rdata = b_rdata[c_sel_q];
endmodule

// File: rtl/pp_store_chk.sv
module pp_store_chk (
    input logic clk,
    input logic rst_n,
    input logic swap_req,
    input logic c_en,
    input logic host_bank,
    input logic swap_pend
);
    // R6: idle-cycle request flips ownership at the next edge
    p_idle_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && !c_en && !swap_pend) |=> (host_bank != $past(host_bank)));

    // R7: no flip may follow a busy cycle
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_en |=> $stable(host_bank));

    // R7: busy-cycle request is held pending
    p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && c_en && !swap_pend) |=> swap_pend);

    // R8: a pending swap resolves with exactly one flip
    p_single_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_pend && !c_en) |=> (!swap_pend && host_bank != $past(host_bank)));

    // R8: ownership stays put without a request
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_req && !swap_pend) |=> ($stable(host_bank) && !swap_pend));
endmodule

bind pp_state_store pp_store_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_req  (swap_req),
    .c_en      (c_en),
    .host_bank (host_bank),
    .swap_pend (swap_pend)
);

// File: tb/sim_pp_state_store.sv
module sim_pp_state_store;
    localparam int AW  = 8;
    localparam int CAW = AW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic swap_req = 1'b0;
    logic host_bank, swap_pend;
    logic h_en = 1'b0, h_we = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [11:0] h_wdata = '0;
    logic [11:0] h_rdata;
    logic c_en = 1'b0, c_we = 1'b0;
    logic [CAW-1:0] c_addr = '0;
    logic [2:0] c_wdata = '0;
    logic [2:0] c_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [11:0] mdl [2][1<<AW];
    logic own_m = 1'b0;
    logic pend_m = 1'b0;

    logic h_issue = 1'b0, c_issue = 1'b0;
    logic [11:0] hq_val[$];
    string       hq_tag[$];
    logic [2:0]  cq_val[$];
    string       cq_tag[$];

    always #10 clk = ~clk;

    pp_state_store #(.HOST_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .swap_req(swap_req),
        .host_bank(host_bank), .swap_pend(swap_pend),
        .h_en(h_en), .h_we(h_we), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_en(c_en), .c_we(c_we), .c_addr(c_addr),
        .c_wdata(c_wdata), .c_rdata(c_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares read results one cycle after issue
    always @(posedge clk) begin
        logic hi, ci;
        hi = h_issue;
        ci = c_issue;
        #2;
        if (hi) chk(hq_tag.pop_front(), 32'(h_rdata), 32'(hq_val.pop_front()));
        if (ci) chk(cq_tag.pop_front(), 32'(c_rdata), 32'(cq_val.pop_front()));
    end

    // Driver: one cycle of stimulus on both ports
    task automatic cyc(input logic he, input logic hw, input logic [AW-1:0] ha,
                       input logic [11:0] hd, input logic ce, input logic cw,
                       input logic [CAW-1:0] ca, input logic [2:0] cd,
                       input logic sw, input string tag);
        logic [11:0] w;
        h_en = he; h_we = hw; h_addr = ha; h_wdata = hd;
        c_en = ce; c_we = cw; c_addr = ca; c_wdata = cd;
        swap_req = sw;
        h_issue = he && !hw;
        c_issue = ce && !cw;
        if (he && !hw) begin hq_val.push_back(mdl[own_m][ha]); hq_tag.push_back(tag); end
        if (ce && !cw) begin
            w = mdl[~own_m][ca[CAW-1:2]];
            cq_val.push_back(w[ca[1:0]*3 +: 3]);
            cq_tag.push_back(tag);
        end
        if (he && hw) mdl[own_m][ha] = hd;
        if (ce && cw) begin
            w = mdl[~own_m][ca[CAW-1:2]];
            w[ca[1:0]*3 +: 3] = cd;
            mdl[~own_m][ca[CAW-1:2]] = w;
        end
        if (pend_m) begin
            if (!ce) begin own_m = ~own_m; pend_m = 1'b0; end
        end else if (sw) begin
            if (!ce) own_m = ~own_m;
            else pend_m = 1'b1;
        end
        @(negedge clk);
        h_en = 0; c_en = 0; swap_req = 0; h_issue = 0; c_issue = 0;
        chk("R6/R7/R8 host_bank", 32'(host_bank), 32'(own_m));
        chk("R7/R8 swap_pend", 32'(swap_pend), 32'(pend_m));
    endtask

    task automatic hwr(input logic [AW-1:0] a, input logic [11:0] d);
        cyc(1, 1, a, d, 0, 0, '0, '0, 0, "R2");
    endtask
    task automatic hrd(input logic [AW-1:0] a, input string tag);
        cyc(1, 0, a, '0, 0, 0, '0, '0, 0, tag);
    endtask
    task automatic cwr(input logic [CAW-1:0] a, input logic [2:0] d);
        cyc(0, 0, '0, '0, 1, 1, a, d, 0, "R4");
    endtask
    task automatic crd(input logic [CAW-1:0] a, input string tag);
        cyc(0, 0, '0, '0, 1, 0, a, '0, 0, tag);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 host_bank", 32'(host_bank), 0);
        chk("R1 swap_pend", 32'(swap_pend), 0);

        // R2: word writes and reads on the host bank
        hwr(0, 12'hABC); hwr(1, 12'h123); hwr(2, 12'hFFF); hwr(3, 12'h000);
        hrd(0, "R2"); hrd(2, "R2"); hrd(1, "R2"); hrd(3, "R2");

        // R3 / R4: build word 5 of the compute bank one state at a time
        cwr({8'd5, 2'd0}, 3'h1); cwr({8'd5, 2'd1}, 3'h2);
        cwr({8'd5, 2'd2}, 3'h5); cwr({8'd5, 2'd3}, 3'h7);
        crd({8'd5, 2'd1}, "R3"); crd({8'd5, 2'd3}, "R3");
        cwr({8'd5, 2'd2}, 3'h0);
        crd({8'd5, 2'd0}, "R4"); crd({8'd5, 2'd1}, "R4");
        crd({8'd5, 2'd2}, "R4"); crd({8'd5, 2'd3}, "R4");

        // R5: host write to word 5 while compute reads its own word 5
        cyc(1, 1, 8'd5, 12'h555, 1, 0, {8'd5, 2'd3}, '0, 0, "R5");
        crd({8'd5, 2'd0}, "R5");

        // R6 + R9: idle swap with a host read in the same cycle
        cyc(1, 0, 8'd0, '0, 0, 0, '0, '0, 1, "R9");
        hrd(5, "R3/R4 packed word");
        chk("R3/R4 literal", 32'(mdl[own_m][5]), 32'h0E11);
        crd({8'd5, 2'd0}, "R5"); crd({8'd5, 2'd1}, "R5");
        crd({8'd0, 2'd2}, "R5");

        // R7 / R8: swap while compute busy, then a second request
        cyc(0, 0, '0, '0, 1, 0, {8'd1, 2'd0}, '0, 1, "R7");
        cyc(0, 0, '0, '0, 1, 0, {8'd1, 2'd1}, '0, 1, "R8");
        cyc(0, 0, '0, '0, 1, 1, {8'd9, 2'd2}, 3'h6, 0, "R7");
        crd({8'd9, 2'd2}, "R7");
        cyc(1, 0, 8'd5, '0, 0, 0, '0, '0, 0, "R9");
        repeat (3) cyc(0, 0, '0, '0, 0, 0, '0, '0, 0, "R8");
        hrd(5, "R7"); crd({8'd9, 2'd2}, "R5");
        hwr(7, 12'h9A3); hrd(7, "R2");

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule